// File: doc/BRIEF.md
# Display Sync Status Flags

This block holds the three read-only status flags of a display controller whose vertical timing can be locked to an external vertical sync input. A loss monitor synchronizes the external vsync into the local clock domain, finds its rising edges and counts line ticks between them. When the controller is in TV sync mode and more line ticks pass than the programmed vertical period allows, a sticky sync error flag is raised.

A frame flag records that a vertical blanking interval has begun since the flag was last cleared. In interlaced scanning only even-field blanking counts. A buffer-select flag reports which of the two frame-buffer start addresses the display is using. It takes the software request only at the start of vertical blanking, so the address never changes in the middle of a frame. Each flag has its own clear strobe, and the display reset clears all three.

Top module: `dsync_status`

## Requirements
- R1: After rst_n is released, every bit of status reads 0.
- R2: status bit 0 is the frame flag, bit 1 is the sync error flag, and bit 2 is the buffer-select flag. A buffer-select value of 0 means buffer 0 is active and 1 means buffer 1 is active.
- R3: A rising edge on ext_vsync is detected 3 clocks after the input goes high and restarts the line counter. If line_tick is high while the counter already holds at least vperiod, with no edge pending, the sync error flag reads 1 on the next clock.
- R4: While tv_sync is 0 the line counter is held at 0 and the sync error flag is never set, however long ext_vsync stays quiet.
- R5: Once set, the sync error flag stays 1 until clr_sync_err or disp_reset is sampled high. It then reads 0 one clock later.
- R6: With scan_mode = 0 (progressive), a vblank_start pulse sets the frame flag, which reads 1 one clock later.
- R7: With scan_mode = 1 (interlaced), vblank_start sets the frame flag only when field_even is 1. An odd-field blanking start leaves the flag at 0.
- R8: The frame flag stays 1 until clr_frame or disp_reset is sampled high, and then reads 0 one clock later.
- R9: When a clear strobe and the set condition of the same flag are sampled in the same clock, the flag reads 1.
- R10: buf_req is latched every clock. The buffer-select flag takes the latched value only on a clock in which vblank_start is high, and does not change on any other clock.
- R11: disp_reset clears all three flags one clock later, and blocks any flag from being set in the clock in which it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_vsync | input | 1 | External vertical sync, asynchronous |
| line_tick | input | 1 | One-clock pulse per line period |
| vperiod | input | PW | Allowed line ticks between vsync edges |
| tv_sync | input | 1 | 1 selects TV sync mode (loss check active) |
| scan_mode | input | 1 | 0 progressive, 1 interlaced |
| field_even | input | 1 | Current field is even (interlaced) |
| vblank_start | input | 1 | One-clock pulse at start of vertical blanking |
| buf_req | input | 1 | Software-requested frame buffer |
| disp_reset | input | 1 | Display reset, clears all flags |
| clr_sync_err | input | 1 | Clear strobe for sync error flag |
| clr_frame | input | 1 | Clear strobe for frame flag |
| status | output | 3 | {buffer select, sync error, frame} |

## Verification
Each flag, clear and display reset produces its result exactly one clock after the controlling input is sampled. The loss check is the exception: an edge on ext_vsync restarts the counter only on the third clock after the input rises, so the clock on which the error appears is counted from the ticks that follow that restart. The scoreboard driver computes a due cycle for each expected value when it applies the stimulus: the current cycle plus one for flags, and the cycle just before and just after the computed error clock for the loss check. The monitor compares each queued item on the falling edge of the cycle it is due, with a mask that limits the comparison to the bits that item concerns.

// File: rtl/dsync_pkg.sv
package dsync_pkg;
  typedef enum logic {
    SCAN_PROG  = 1'b0,
    SCAN_ILACE = 1'b1
  } scan_e;

  localparam int ST_FRAME = 0;
  localparam int ST_SERR  = 1;
  localparam int ST_BUF   = 2;
  localparam int ST_W     = 3;
endpackage

// File: rtl/dsync_vs_edge.sv
module dsync_vs_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vs_in,
  output logic vs_rise
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], vs_in};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign vs_rise = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/dsync_loss_mon.sv
module dsync_loss_mon #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vs_rise,
  input  logic          line_tick,
  input  logic [PW-1:0] vperiod,
  input  logic          tv_sync,
  input  logic          disp_reset,
  input  logic          clr,
  output logic          err
);
  logic [PW-1:0] cnt_q, cnt_d;
  logic          err_q, err_d;
  logic          miss;

  always_comb begin
    miss  = tv_sync & ~disp_reset & ~vs_rise & line_tick & (cnt_q >= vperiod);
    cnt_d = cnt_q;
    if (!tv_sync || disp_reset || vs_rise || miss)
      cnt_d = '0;
    else if (line_tick)
      cnt_d = cnt_q + 1'b1;
    err_d = miss | (err_q & ~clr & ~disp_reset);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  assign err = err_q;
endmodule

// File: rtl/dsync_frame_flag.sv
module dsync_frame_flag
  import dsync_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic scan_mode,
  input  logic field_even,
  input  logic vblank_start,
  input  logic disp_reset,
  input  logic clr,
  output logic flag
);
  scan_e mode;
  logic  set, flag_q, flag_d;

  always_comb begin
    mode   = scan_e'(scan_mode);
    set    = vblank_start & ~disp_reset & ((mode == SCAN_PROG) | field_even);
    flag_d = set | (flag_q & ~clr & ~disp_reset);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/dsync_buf_sel.sv
module dsync_buf_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic buf_req,
  input  logic vblank_start,
  input  logic disp_reset,
  output logic sel
);
  logic req_q, req_d, sel_q, sel_d;
  logic take_en;

  always_comb begin
    req_d   = disp_reset ? 1'b0 : buf_req;
    take_en = vblank_start & ~disp_reset;
    sel_d   = sel_q;
    if (disp_reset)   sel_d = 1'b0;
    else if (take_en) sel_d = req_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      req_q <= req_d;
      sel_q <= sel_d;
    end
  end

  assign sel = sel_q;
endmodule

// File: rtl/dsync_status.sv
module dsync_status
  import dsync_pkg::*;
#(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_vsync,
  input  logic          line_tick,
  input  logic [PW-1:0] vperiod,
  input  logic          tv_sync,
  input  logic          scan_mode,
  input  logic          field_even,
  input  logic          vblank_start,
  input  logic          buf_req,
  input  logic          disp_reset,
  input  logic          clr_sync_err,
  input  logic          clr_frame,
  output logic [2:0]    status
);
  logic vs_rise, serr, frame, bsel;

  dsync_vs_edge #(.SYNC_STAGES(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .vs_in(ext_vsync), .vs_rise(vs_rise)
  );

  dsync_loss_mon #(.PW(PW)) u_loss (
    .clk(clk), .rst_n(rst_n), .vs_rise(vs_rise), .line_tick(line_tick),
    .vperiod(vperiod), .tv_sync(tv_sync), .disp_reset(disp_reset),
    .clr(clr_sync_err), .err(serr)
  );

  dsync_frame_flag u_frame (
    .clk(clk), .rst_n(rst_n), .scan_mode(scan_mode), .field_even(field_even),
    .vblank_start(vblank_start), .disp_reset(disp_reset), .clr(clr_frame),
    .flag(frame)
  );

  dsync_buf_sel u_buf (
    .clk(clk), .rst_n(rst_n), .buf_req(buf_req), .vblank_start(vblank_start),
    .disp_reset(disp_reset), .sel(bsel)
  );

  always_comb begin
    status           = '0;
    status[ST_FRAME] = frame;
    status[ST_SERR]  = serr;
    status[ST_BUF]   = bsel;
  end
endmodule

// File: rtl/dsync_status_chk.sv
module dsync_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tv_sync,
  input logic       vblank_start,
  input logic       disp_reset,
  input logic       clr_sync_err,
  input logic       clr_frame,
  input logic [2:0] status
);
  // R11: display reset leaves every flag at 0
  a_r11_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    disp_reset |=> (status == 3'b000));

  // R4: sync error only rises after a cycle in TV sync mode
  a_r4_err_needs_tv: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(tv_sync));

  // R5: sync error is sticky without a clear
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && !clr_sync_err && !disp_reset) |=> status[1]);

  // R8: frame flag is sticky without a clear
  a_r8_frame_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !clr_frame && !disp_reset) |=> status[0]);

  // R6: frame flag rises only after a blanking start
  a_r6_frame_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> $past(vblank_start));

  // R10: buffer select holds outside blanking start
  a_r10_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!vblank_start && !disp_reset) |=> $stable(status[2]));
endmodule

bind dsync_status dsync_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tv_sync(tv_sync), .vblank_start(vblank_start),
  .disp_reset(disp_reset), .clr_sync_err(clr_sync_err), .clr_frame(clr_frame),
  .status(status)
);

// File: tb/tb_dsync_status.sv
module tb_dsync_status;
  localparam int PW = 12;

  logic clk, rst_n, ext_vsync, line_tick, tv_sync, scan_mode, field_even;
  logic vblank_start, buf_req, disp_reset, clr_sync_err, clr_frame;
  logic [PW-1:0] vperiod;
  logic [2:0] status;

  dsync_status #(.PW(PW)) dut (
    .clk(clk), .rst_n(rst_n), .ext_vsync(ext_vsync), .line_tick(line_tick),
    .vperiod(vperiod), .tv_sync(tv_sync), .scan_mode(scan_mode),
    .field_even(field_even), .vblank_start(vblank_start), .buf_req(buf_req),
    .disp_reset(disp_reset), .clr_sync_err(clr_sync_err), .clr_frame(clr_frame),
    .status(status)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    int         due;
    logic [2:0] val;
    logic [2:0] mask;
    string      tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        checks++;
        if ((status & q[i].mask) != (q[i].val & q[i].mask)) begin
          errors++;
          $display("FAIL %s cyc %0d actual %b expected %b mask %b",
                   q[i].tag, cyc, status, q[i].val, q[i].mask);
        end
        q.delete(i);
      end
    end
  end

  task automatic expect_at(input int d, input logic [2:0] v,
                           input logic [2:0] m, input string t);
    exp_t e;
    e.due = cyc + d; e.val = v; e.mask = m; e.tag = t;
    q.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Holds ext_vsync high for two clocks, starting at the current negedge.
  task automatic vs_pulse();
    ext_vsync = 1'b1; step(2); ext_vsync = 1'b0;
  endtask

  initial begin
    int c;
    rst_n = 0; ext_vsync = 0; line_tick = 1; vperiod = 4; tv_sync = 0;
    scan_mode = 0; field_even = 0; vblank_start = 0; buf_req = 0;
    disp_reset = 0; clr_sync_err = 0; clr_frame = 0;
    step(3);
    rst_n = 1;
    expect_at(1, 3'b000, 3'b111, "R1 reset state");
    step(2);

    // R4: no check outside TV sync mode
    step(20);
    expect_at(1, 3'b000, 3'b010, "R4 no error without tv_sync");
    step(2);

    // R3: missing edge raises error
    c = cyc;
    tv_sync = 1;
    expect_at(7, 3'b000, 3'b010, "R3 error not yet");
    expect_at(8, 3'b010, 3'b010, "R3 error on missed edge");
    vs_pulse();
    step(10);
    expect_at(1, 3'b010, 3'b010, "R5 error sticky");
    step(1);
    tv_sync = 0; clr_sync_err = 1;
    expect_at(1, 3'b000, 3'b010, "R5 error cleared");
    step(1); clr_sync_err = 0;
    step(2);

    // R9: clear and set in the same clock
    tv_sync = 1;
    expect_at(7, 3'b000, 3'b010, "R9 before set");
    expect_at(8, 3'b010, 3'b010, "R9 set wins over clear");
    vs_pulse();
    step(5);
    clr_sync_err = 1;
    step(1); clr_sync_err = 0;
    tv_sync = 0;
    step(3);
    clr_sync_err = 1;
    expect_at(1, 3'b000, 3'b010, "R5 clear after R9");
    step(1); clr_sync_err = 0;

    // R3: regular edges keep error low
    tv_sync = 1;
    for (int k = 0; k < 10; k++) begin
      vs_pulse(); step(2);
    end
    expect_at(1, 3'b000, 3'b010, "R3 regular edges no error");
    step(1);
    tv_sync = 0;
    step(2);

    // R6 / R8: progressive frame flag
    scan_mode = 0;
    vblank_start = 1;
    expect_at(1, 3'b001, 3'b101, "R6 frame set, buffer stays 0");
    step(1); vblank_start = 0;
    step(3);
    expect_at(1, 3'b001, 3'b001, "R8 frame sticky");
    step(1);
    clr_frame = 1;
    expect_at(1, 3'b000, 3'b001, "R8 frame cleared");
    step(1); clr_frame = 0;
    vblank_start = 1; clr_frame = 1;
    expect_at(1, 3'b001, 3'b001, "R9 frame set wins");
    step(1); vblank_start = 0;
    expect_at(1, 3'b000, 3'b001, "R8 frame cleared again");
    step(1); clr_frame = 0;

    // R7: interlaced, odd vs even field
    scan_mode = 1; field_even = 0; vblank_start = 1;
    expect_at(1, 3'b000, 3'b001, "R7 odd field ignored");
    step(1); vblank_start = 0;
    step(2);
    expect_at(1, 3'b000, 3'b001, "R7 still 0 after odd field");
    step(1);
    field_even = 1; vblank_start = 1;
    expect_at(1, 3'b001, 3'b001, "R7 even field sets");
    step(1); vblank_start = 0; field_even = 0;

    // R10: buffer select only at blanking start
    buf_req = 1;
    step(3);
    expect_at(1, 3'b000, 3'b100, "R10 no switch mid-frame");
    step(1);
    vblank_start = 1;
    expect_at(1, 3'b100, 3'b100, "R10 switch at blanking");
    step(1); vblank_start = 0;
    buf_req = 0;
    step(3);
    expect_at(1, 3'b100, 3'b100, "R10 hold after request drops");
    step(1);

    // R2 / R11: all flags set, then display reset
    tv_sync = 1;
    step(10);
    tv_sync = 0;
    expect_at(1, 3'b111, 3'b111, "R2 status bit layout");
    step(2);
    disp_reset = 1; vblank_start = 1; field_even = 1;
    expect_at(1, 3'b000, 3'b111, "R11 display reset clears all");
    step(1); disp_reset = 0; vblank_start = 0; field_even = 0;
    step(3);
    expect_at(1, 3'b000, 3'b111, "R11 flags stay clear");
    step(3);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at cyc %0d actual running expected done", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule